// File: doc/BRIEF.md
# Longest-Pulse Winning Class Detector

This block picks a winner among several classes, where each class reports its similarity score as the width of a single pulse. All class pulses begin together at the start of an evaluation window. The block does not measure or compare any widths. It forms the OR of all class pulses, waits for that combined pulse to end, and takes as winner the class that was still high just before the end. The class that stays high longest is the last one left, so it wins.

A sampling clock runs much faster than the evaluation window. Each class input passes through a synchroniser. The synchronised copy feeds both the OR tree and the capture stage, so both see the same sample alignment. When the combined pulse falls, a one-hot winner vector is registered and a one-cycle valid strobe is raised. Ties go to the lowest class index. A window with no pulse gives no strobe and leaves the previous winner in place.

Top module: `lpw_top`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, that edge clears `winner_o` to all zeros and `valid_o` to 0.
- R2: When every bit of `pulse_i` is first sampled low at edge m, after a window in which at least one bit was high, `valid_o` is 0 after edges m and m+1, is 1 after edge m+2, and returns to 0 after edge m+3.
- R3: When `valid_o` is 1, `winner_o` has exactly one bit set. Bit i of `winner_o` (bit 0 is class 0) is set for the class whose pulse input stayed high for the most sampling edges.
- R4: When two or more classes share the longest width, the set bit of `winner_o` is the lowest index among them.
- R5: `winner_o` never has more than one bit set.
- R6: A window in which every `pulse_i` bit stays low produces no `valid_o` strobe, and `winner_o` keeps the value from the last decision.
- R7: `valid_o` stays 0 while any class pulse is still high, even after other class pulses have already ended.
- R8: A reset raised during an open window abandons that window. No decision is reported for it, and a later window is decided normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_i | input | NUM_CLASSES | One width-coded pulse per class, asynchronous to `clk` |
| winner_o | output | NUM_CLASSES | Registered one-hot winner, bit i for class i |
| valid_o | output | 1 | One-cycle strobe marking a new decision |

## Verification
A bad synchroniser or phase bit shows up at the ports as a strobe that comes one or two edges early or late relative to the edge where all inputs first read low. Such an error can also produce a strobe during a window that is still open. A wrong priority stage or capture vector shows up as a wrong or multi-hot winner in the same cycle as the strobe. A bad hold path shows up as a change in `winner_o` after an empty window or between strobes. The bench samples each window on the exact edges from R2, so any of these errors appears within three cycles of the falling edge that caused it.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    // Default number of competing classes
    localparam int unsigned LPW_CLASSES_DEF = 10;
    // Default synchroniser depth per class input
    localparam int unsigned LPW_SYNC_DEF    = 2;

    // Whether the combined pulse was high on the previous sample
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_phase_e;

endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
    parameter int unsigned W      = 10,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] last_o
);
    // One extra stage beyond the synchroniser holds the previous sample
    localparam int unsigned DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.pipe[STAGES-1];
    assign last_o = st_q.pipe[STAGES];

endmodule

// File: rtl/lpw_or_tree.sv
module lpw_or_tree #(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] leaves,
    output logic         root
);
    localparam int unsigned LEVELS = (W < 2) ? 1 : $clog2(W);
    localparam int unsigned PAD    = 1 << LEVELS;

    for (genvar l = 0; l <= LEVELS; l++) begin : level
        logic [(PAD >> l)-1:0] v;
        if (l == 0) begin : g_leaf
            for (genvar j = 0; j < PAD; j++) begin : g_bit
                if (j < W) begin : g_real
                    assign v[j] = leaves[j];
                end else begin : g_pad
                    assign v[j] = 1'b0;
                end
            end
        end else begin : g_node
            for (genvar j = 0; j < (PAD >> l); j++) begin : g_bit
                assign v[j] = level[l-1].v[2*j] | level[l-1].v[2*j+1];
            end
        end
    end

    assign root = level[LEVELS].v[0];

endmodule

// File: rtl/lpw_pick.sv
module lpw_pick #(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] gnt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Isolate the lowest set bit: lowest index wins a tie
    assign gnt = req & (~req + ONE);

endmodule

// File: rtl/lpw_capture.sv
module lpw_capture
    import lpw_pkg::*;
#(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] last_i,
    input  logic         any_i,
    output logic [W-1:0] winner_o,
    output logic         valid_o
);
    typedef struct packed {
        win_phase_e   phase;
        logic [W-1:0] winner;
        logic         valid;
    } cap_state_t;

    cap_state_t   st_d, st_q;
    logic [W-1:0] pick_gnt;
    logic         fall;

    lpw_pick #(.W(W)) u_pick (
        .req (last_i),
        .gnt (pick_gnt)
    );

    // Combined pulse was high on the last sample and is low now
    assign fall = (st_q.phase == WIN_OPEN) && !any_i;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.phase = any_i ? WIN_OPEN : WIN_IDLE;
        if (fall) begin
            st_d.winner = pick_gnt;
            st_d.valid  = 1'b1;
        end
        if (rst) begin
            st_d.phase  = WIN_IDLE;
            st_d.winner = '0;
            st_d.valid  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign winner_o = st_q.winner;
    assign valid_o  = st_q.valid;

endmodule

// File: rtl/lpw_top.sv
module lpw_top #(
    parameter int unsigned NUM_CLASSES = lpw_pkg::LPW_CLASSES_DEF,
    parameter int unsigned SYNC_STAGES = lpw_pkg::LPW_SYNC_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CLASSES-1:0] pulse_i,
    output logic [NUM_CLASSES-1:0] winner_o,
    output logic                   valid_o
);
    logic [NUM_CLASSES-1:0] sync_now;
    logic [NUM_CLASSES-1:0] sync_last;
    logic                   any_now;

    lpw_sync #(.W(NUM_CLASSES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (pulse_i),
        .sync_o (sync_now),
        .last_o (sync_last)
    );

    lpw_or_tree #(.W(NUM_CLASSES)) u_or (
        .leaves (sync_now),
        .root   (any_now)
    );

    lpw_capture #(.W(NUM_CLASSES)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .last_i   (sync_last),
        .any_i    (any_now),
        .winner_o (winner_o),
        .valid_o  (valid_o)
    );

endmodule

// File: rtl/lpw_check.sv
module lpw_check #(
    parameter int unsigned W = 10
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] winner_o,
    input logic         valid_o,
    input logic [W-1:0] sync_last,
    input logic         any_now
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (winner_o == '0) && !valid_o);

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ($past(sync_last) != '0) && !$past(any_now));

    assert_from_survivors_R3: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (winner_o != '0) && ((winner_o & ~$past(sync_last)) == '0));

    assert_lowest_tie_R4: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (($past(sync_last) & (winner_o - ONE)) == '0));

    assert_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(winner_o));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && !$past(rst)) |-> $stable(winner_o));

endmodule

bind lpw_top lpw_check #(.W(NUM_CLASSES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .winner_o  (winner_o),
    .valid_o   (valid_o),
    .sync_last (sync_last),
    .any_now   (any_now)
);

// File: tb/tb_lpw_top.sv
module tb_lpw_top;
    localparam int NC = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] pulse_i = '0;
    logic [NC-1:0] winner_o;
    logic          valid_o;

    int vectors = 0;
    int fails   = 0;
    bit reported = 1'b0;
    logic [NC-1:0] held_win = '0;

    always #2 clk = ~clk;

    lpw_top #(.NUM_CLASSES(NC), .SYNC_STAGES(2)) dut (
        .clk      (clk),
        .rst      (rst),
        .pulse_i  (pulse_i),
        .winner_o (winner_o),
        .valid_o  (valid_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // Drives one window with the given widths in cycles and checks the result
    task automatic run_window(input int w [NC], input string req);
        int mx = 0;
        logic [NC-1:0] exp_win = '0;
        bit early = 1'b0;
        for (int c = 0; c < NC; c++) if (w[c] > mx) mx = w[c];
        for (int c = NC-1; c >= 0; c--) if (w[c] == mx && mx > 0) exp_win = '0 | (1 << c);
        for (int cyc = 0; cyc < mx; cyc++) begin
            @(negedge clk);
            if (valid_o) early = 1'b1;
            for (int c = 0; c < NC; c++) pulse_i[c] = (cyc < w[c]);
        end
        @(negedge clk);
        if (valid_o) early = 1'b1;
        pulse_i = '0;
        chk(!early, "R7 no strobe while open", 32'(early), 0);
        @(posedge clk); #1;
        chk(!valid_o, "R2 low after edge m", 32'(valid_o), 0);
        @(posedge clk); #1;
        chk(!valid_o, "R2 low after edge m+1", 32'(valid_o), 0);
        @(posedge clk); #1;
        if (mx > 0) begin
            chk(valid_o, "R2 strobe after edge m+2", 32'(valid_o), 1);
            chk(winner_o == exp_win, req, 32'(winner_o), 32'(exp_win));
            chk($countones(winner_o) <= 1, "R5 one-hot", 32'(winner_o), 32'(exp_win));
            held_win = exp_win;
        end else begin
            chk(!valid_o, "R6 no strobe on empty window", 32'(valid_o), 0);
        end
        @(posedge clk); #1;
        chk(!valid_o, "R2 strobe lasts one cycle", 32'(valid_o), 0);
        chk(winner_o == held_win, "R6 winner held after strobe", 32'(winner_o), 32'(held_win));
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1; pulse_i = '0;
        repeat (5) @(negedge clk);
        chk(winner_o == '0, "R1 winner cleared", 32'(winner_o), 0);
        chk(!valid_o, "R1 valid cleared", 32'(valid_o), 0);
        rst = 1'b0;
        held_win = '0;
    endtask

    task automatic t_single();
        int w [NC] = '{default: 0};
        w[3] = 4;
        run_window(w, "R3 single class 3");
    endtask

    task automatic t_distinct();
        int w [NC] = '{2, 5, 3, 9, 1, 4, 7, 6, 8, 3};
        run_window(w, "R3 longest is class 3");
    endtask

    task automatic t_top_index();
        int w [NC] = '{default: 2};
        w[9] = 3;
        run_window(w, "R3 longest is class 9");
    endtask

    task automatic t_tie();
        int w [NC] = '{1, 3, 6, 2, 4, 6, 5, 1, 2, 3};
        run_window(w, "R4 tie of 2 and 5 gives 2");
    endtask

    task automatic t_all_equal();
        int w [NC] = '{default: 5};
        run_window(w, "R4 all tied gives class 0");
    endtask

    task automatic t_stagger();
        int w [NC] = '{default: 0};
        w[0] = 1; w[4] = 6; w[9] = 12;
        run_window(w, "R7 staggered ends give class 9");
    endtask

    task automatic t_idle();
        int w [NC] = '{default: 0};
        bit seen = 1'b0;
        run_window(w, "R6 empty window");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (valid_o) seen = 1'b1;
        end
        chk(!seen, "R6 idle gives no strobe", 32'(seen), 0);
        chk(winner_o == held_win, "R6 idle holds winner", 32'(winner_o), 32'(held_win));
    endtask

    task automatic t_reset_mid();
        int w [NC] = '{default: 0};
        bit seen = 1'b0;
        @(negedge clk); pulse_i = '0; pulse_i[4] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b1; pulse_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        held_win = '0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (valid_o) seen = 1'b1;
        end
        chk(!seen, "R8 abandoned window gives no strobe", 32'(seen), 0);
        chk(winner_o == '0, "R8 winner cleared by reset", 32'(winner_o), 0);
        w[1] = 3;
        run_window(w, "R8 recovery window gives class 1");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        t_reset();
        t_single();
        t_distinct();
        t_top_index();
        t_tie();
        t_all_equal();
        t_stagger();
        t_idle();
        t_reset_mid();
        report();
    end

endmodule